// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block sits at the front of a mobile DDR SDRAM controller and drives the memory command pins during power-up. While the controller is held in its configure state, software writes direct-command words. Each word names one of four commands (NOP, precharge-all, auto-refresh, or mode/extended-mode register load), a target chip, a bank and an address value. An accepted word appears on the registered pins for exactly one cycle. The block then withholds its ready flag until the minimum gap for that command has elapsed. The gap lengths come from timing inputs that the surrounding controller holds.

A separate state write moves the controller between configure and go. In go, direct commands are refused. A down-counter reloads from the refresh-interval input and issues an auto-refresh to every chip each time it expires. It never violates the refresh recovery gap. The usual start-up order is NOP, precharge-all, two auto-refreshes, the extended mode register (bank 2), then the mode register. For example, value 0x32 gives CAS latency 3 and burst length 4.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset the block is in the configure state. `cmd_ready` is 1 and `go_active` is 0. All chip selects are high, RAS/CAS/WE are high, and bank and address are 0.
- R2: The direct-command word carries the command code in bits [19:18], the chip number in [21:20], the bank in [17:16] and the address value in [15:0]. A word accepted (`cmd_wr` high while `cmd_ready` high) appears on the pins in the next cycle for one cycle. Only the selected chip's `mem_cs_n` is low, and a chip number with no matching chip selects none. Bank and address follow the word.
- R3: Pin encodings (RAS,CAS,WE) are as follows. Code 0 is precharge-all = 0,1,0, with address bit 10 forced to 1. Code 1 is auto-refresh = 0,0,1. Code 2 is mode-register load = 0,0,0, with the address value as the mode word. Code 3 is NOP = 1,1,1, with chip select low.
- R4: After a direct command appears, `cmd_ready` stays low so that the next command can appear no earlier than G cycles later. G is `t_rp` after precharge-all, `t_rfc` after auto-refresh, `t_mrd` after a mode load and 1 after NOP, and a value of 0 counts as 1. Back-to-back writes achieve exactly G.
- R5: A `cmd_wr` while `cmd_ready` is low is dropped: no command appears and nothing is queued.
- R6: A state write with value 4 selects configure and value 0 selects go. Any other value has no effect. In go, `go_active` is 1, `cmd_ready` is 0 and direct writes are dropped.
- R7: In go with interval I (0 counts as 1), the first periodic auto-refresh appears I cycles after the edge that entered go, provided no gap is pending. Later ones are spaced max(I, `t_rfc`) cycles apart.
- R8: A periodic refresh drives every chip select low with RAS=0, CAS=0, WE=1, bank 0 and address 0.
- R9: Returning to configure stops periodic refreshes, and `cmd_ready` rises once any pending gap has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | State register write strobe |
| cfg_val | input | 3 | State value: 4 configure, 0 go |
| cmd_wr | input | 1 | Direct-command write strobe |
| cmd_word | input | 22 | Direct-command word |
| t_mrd | input | TW | Gap after a mode-register load |
| t_rp | input | TW | Gap after precharge-all |
| t_rfc | input | TW | Gap after auto-refresh |
| ref_interval | input | RW | Periodic refresh interval in cycles |
| cmd_ready | output | 1 | Direct command may be written |
| go_active | output | 1 | Controller is in the go state |
| mem_cs_n | output | NCHIP | Active-low chip selects |
| mem_ras_n | output | 1 | Active-low row strobe |
| mem_cas_n | output | 1 | Active-low column strobe |
| mem_we_n | output | 1 | Active-low write enable |
| mem_ba | output | 2 | Bank address |
| mem_addr | output | AW | Address pins |

## Verification
The hardest case to reach from the ports is the periodic refresh that is held off by its own recovery gap. It only occurs when the programmed interval is shorter than `t_rfc`. The bench enters go with the gap already drained and sweeps the interval from 0 through values below, at and above `t_rfc`, so that the spacing moves from gap-limited to counter-limited. The same sweep times the first refresh against the state-change edge. It also writes a direct command in the go entry cycle, so that an unwanted issue would show up as an early or malformed refresh.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    localparam int CHIP_LSB = 20;
    localparam int CMD_LSB  = 18;
    localparam int BANK_LSB = 16;
    localparam int FIELD_W  = 16;
    localparam int AP_BIT   = 10;

    localparam logic [2:0] STATE_CONFIGURE = 3'd4;
    localparam logic [2:0] STATE_GO        = 3'd0;

    typedef enum logic [1:0] {
        DC_PALL = 2'd0,
        DC_AREF = 2'd1,
        DC_MRS  = 2'd2,
        DC_NOP  = 2'd3
    } dcmd_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = strobe_t'(3'b111);

    function automatic strobe_t strobe_of(input dcmd_e c);
        strobe_t s;
        unique case (c)
            DC_PALL: s = strobe_t'(3'b010);
            DC_AREF: s = strobe_t'(3'b001);
            DC_MRS:  s = strobe_t'(3'b000);
            default: s = strobe_t'(3'b111);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] gap,
    output logic          idle
);

    logic [TW-1:0] cnt_d, cnt_q;

    // the command cycle itself counts as the first cycle of the gap
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (gap == '0) ? '0 : gap - TW'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign idle = (cnt_q == '0);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int RW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          fire,
    input  logic [RW-1:0] interval,
    output logic          due
);

    logic [RW-1:0] cnt_d, cnt_q;
    logic [RW-1:0] reload;

    assign reload = (interval == '0) ? '0 : interval - RW'(1);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || fire) begin
            cnt_d = reload;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - RW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // holds at zero while a recovery gap blocks the refresh
    assign due = run && (cnt_q == '0);

endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_init_pkg::*;
#(
    parameter int NCHIP = 2,
    parameter int AW    = 16
) (
    input  logic               issue,
    input  logic               refresh,
    input  dcmd_e              code,
    input  logic [1:0]         chip,
    input  logic [1:0]         bank,
    input  logic [FIELD_W-1:0] field,
    output logic [NCHIP-1:0]   cs_n,
    output strobe_t            str,
    output logic [1:0]         ba,
    output logic [AW-1:0]      addr
);

    for (genvar i = 0; i < NCHIP; i++) begin : g_cs
        assign cs_n[i] = !(refresh || (issue && (chip == 2'(i))));
    end

    always_comb begin
        str  = STROBE_IDLE;
        ba   = '0;
        addr = '0;
        if (refresh) begin
            str = strobe_of(DC_AREF);
        end else if (issue) begin
            str  = strobe_of(code);
            ba   = bank;
            addr = field[AW-1:0];
            if (code == DC_PALL) begin
                addr[AP_BIT] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int NCHIP = 2,
    parameter int AW    = 16,
    parameter int TW    = 4,
    parameter int RW    = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [2:0]            cfg_val,
    input  logic                  cmd_wr,
    input  logic [CHIP_LSB+1:0]   cmd_word,
    input  logic [TW-1:0]         t_mrd,
    input  logic [TW-1:0]         t_rp,
    input  logic [TW-1:0]         t_rfc,
    input  logic [RW-1:0]         ref_interval,
    output logic                  cmd_ready,
    output logic                  go_active,
    output logic [NCHIP-1:0]      mem_cs_n,
    output logic                  mem_ras_n,
    output logic                  mem_cas_n,
    output logic                  mem_we_n,
    output logic [1:0]            mem_ba,
    output logic [AW-1:0]         mem_addr
);

    typedef struct packed {
        logic             in_cfg;
        logic [NCHIP-1:0] cs_n;
        strobe_t          str;
        logic [1:0]       ba;
        logic [AW-1:0]    addr;
    } regs_t;

    localparam regs_t REGS_RESET = '{
        in_cfg: 1'b1,
        cs_n:   '1,
        str:    STROBE_IDLE,
        ba:     '0,
        addr:   '0
    };

    regs_t r_d, r_q;

    logic             gap_idle;
    logic             ref_due;
    logic             accept;
    logic             ref_fire;
    logic             gap_load;
    logic [TW-1:0]    gap_val;
    dcmd_e            w_code;
    logic [NCHIP-1:0] dec_cs_n;
    strobe_t          dec_str;
    logic [1:0]       dec_ba;
    logic [AW-1:0]    dec_addr;

    assign w_code   = dcmd_e'(cmd_word[CMD_LSB +: 2]);
    assign accept   = cmd_wr && r_q.in_cfg && gap_idle;
    assign ref_fire = ref_due && gap_idle;
    assign gap_load = accept || ref_fire;

    always_comb begin
        if (ref_fire) begin
            gap_val = t_rfc;
        end else begin
            unique case (w_code)
                DC_PALL: gap_val = t_rp;
                DC_AREF: gap_val = t_rfc;
                DC_MRS:  gap_val = t_mrd;
                default: gap_val = TW'(1);
            endcase
        end
    end

    sdram_gap_timer #(.TW(TW)) i_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gap_load),
        .gap   (gap_val),
        .idle  (gap_idle)
    );

    sdram_refresh_timer #(.RW(RW)) i_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (!r_q.in_cfg),
        .fire     (ref_fire),
        .interval (ref_interval),
        .due      (ref_due)
    );

    sdram_cmd_decode #(.NCHIP(NCHIP), .AW(AW)) i_dec (
        .issue   (accept),
        .refresh (ref_fire),
        .code    (w_code),
        .chip    (cmd_word[CHIP_LSB +: 2]),
        .bank    (cmd_word[BANK_LSB +: 2]),
        .field   (cmd_word[FIELD_W-1:0]),
        .cs_n    (dec_cs_n),
        .str     (dec_str),
        .ba      (dec_ba),
        .addr    (dec_addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.cs_n = dec_cs_n;
        r_d.str  = dec_str;
        r_d.ba   = dec_ba;
        r_d.addr = dec_addr;
        if (cfg_wr) begin
            if (cfg_val == STATE_CONFIGURE) begin
                r_d.in_cfg = 1'b1;
            end else if (cfg_val == STATE_GO) begin
                r_d.in_cfg = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = r_q.in_cfg && gap_idle;
    assign go_active = !r_q.in_cfg;
    assign mem_cs_n  = r_q.cs_n;
    assign mem_ras_n = r_q.str.ras_n;
    assign mem_cas_n = r_q.str.cas_n;
    assign mem_we_n  = r_q.str.we_n;
    assign mem_ba    = r_q.ba;
    assign mem_addr  = r_q.addr;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
    parameter int NCHIP = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_wr,
    input logic [1:0]       dcode,
    input logic             cmd_ready,
    input logic             go_active,
    input logic [NCHIP-1:0] mem_cs_n,
    input logic             mem_ras_n,
    input logic             mem_cas_n,
    input logic             mem_we_n,
    input logic             mem_a10
);

    assert_ready_only_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        go_active |-> !cmd_ready);

    assert_issue_row_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_ready && dcode != 2'd3) |=> (!mem_ras_n && $countones(~mem_cs_n) <= 1));

    assert_nop_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_ready && dcode == 2'd3) |=> (mem_ras_n && mem_cas_n && mem_we_n));

    assert_pall_a10_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_ready && dcode == 2'd0) |=> (mem_a10 && !mem_ras_n && mem_cas_n && !mem_we_n));

    assert_multi_cs_refresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~mem_cs_n) > 1) |-> (!mem_ras_n && !mem_cas_n && mem_we_n));

    assert_cfg_single_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!go_active && !$past(go_active)) |-> $onehot0(~mem_cs_n));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(.NCHIP(NCHIP)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .dcode     (cmd_word[19:18]),
    .cmd_ready (cmd_ready),
    .go_active (go_active),
    .mem_cs_n  (mem_cs_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_a10   (mem_addr[10])
);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

    localparam int NCHIP = 2;
    localparam int AW    = 16;
    localparam int TW    = 4;
    localparam int RW    = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [2:0]        cfg_val = 3'd0;
    logic              cmd_wr = 1'b0;
    logic [21:0]       cmd_word = '0;
    logic [TW-1:0]     t_mrd = 4'd2;
    logic [TW-1:0]     t_rp = 4'd4;
    logic [TW-1:0]     t_rfc = 4'd11;
    logic [RW-1:0]     ref_interval = 11'd1037;
    logic              cmd_ready;
    logic              go_active;
    logic [NCHIP-1:0]  mem_cs_n;
    logic              mem_ras_n, mem_cas_n, mem_we_n;
    logic [1:0]        mem_ba;
    logic [AW-1:0]     mem_addr;

    sdram_init_seq #(.NCHIP(NCHIP), .AW(AW), .TW(TW), .RW(RW)) i_sdram_init_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_val(cfg_val),
        .cmd_wr(cmd_wr), .cmd_word(cmd_word), .t_mrd(t_mrd), .t_rp(t_rp),
        .t_rfc(t_rfc), .ref_interval(ref_interval), .cmd_ready(cmd_ready),
        .go_active(go_active), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
        .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_ba(mem_ba),
        .mem_addr(mem_addr)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] PINS_IDLE    = {9'b0, 2'b11, 3'b111, 2'b00, 16'h0000};
    localparam logic [31:0] PINS_REFRESH = {9'b0, 2'b00, 3'b001, 2'b00, 16'h0000};

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pins();
        return {9'b0, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_ba, mem_addr};
    endfunction

    function automatic logic [31:0] exp_pins(input logic [21:0] w);
        logic [1:0]  cs;
        logic [2:0]  s;
        logic [15:0] a;
        cs = 2'b11;
        if (w[21:20] == 2'd0) cs[0] = 1'b0;
        if (w[21:20] == 2'd1) cs[1] = 1'b0;
        case (w[19:18])
            2'd0:    s = 3'b010;
            2'd1:    s = 3'b001;
            2'd2:    s = 3'b000;
            default: s = 3'b111;
        endcase
        a = w[15:0];
        if (w[19:18] == 2'd0) a[10] = 1'b1;
        return {9'b0, cs, s, w[17:16], a};
    endfunction

    function automatic int gap_of(input logic [1:0] code);
        int g;
        case (code)
            2'd0:    g = int'(t_rp);
            2'd1:    g = int'(t_rfc);
            2'd2:    g = int'(t_mrd);
            default: g = 1;
        endcase
        return (g < 1) ? 1 : g;
    endfunction

    task automatic issue(input logic [21:0] w, output int t);
        while (!cmd_ready) @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_word = w;
        @(negedge clk);
        cmd_wr = 1'b0;
        t = cyc;
    endtask

    task automatic wait_refresh(output int t);
        t = -1;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            cmd_wr = 1'b0;
            if (mem_cs_n != '1) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic write_cfg(input logic [2:0] v);
        cfg_wr  = 1'b1;
        cfg_val = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ta, tb, t1, t2, c0, idle_bad, exp_gap;
        logic [21:0] w;
        logic [21:0] seq [6];
        int ivals [8];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 pins", pins(), PINS_IDLE);
        check_eq("R1 ready/go", {30'b0, cmd_ready, go_active}, 32'h2);

        // R2 R3 R4: power-up order with the nominal gaps
        seq[0] = 22'h0c0000; seq[1] = 22'h000000; seq[2] = 22'h040000;
        seq[3] = 22'h040000; seq[4] = 22'h0a0000; seq[5] = 22'h080032;
        ta = 0;
        for (int i = 0; i < 6; i++) begin
            issue(seq[i], tb);
            check_eq("R3 init pins", pins(), exp_pins(seq[i]));
            if (i > 0) check_eq("R4 init gap", 32'(tb - ta), 32'(gap_of(seq[i-1][19:18])));
            ta = tb;
        end
        check_eq("R3 mode word CL3 BL4", {16'b0, mem_addr}, 32'h32);

        // R2 R3 R4: sweep over codes, chips, banks, address and gap values
        for (int i = 0; i < 128; i++) begin
            while (!cmd_ready) @(negedge clk);
            t_rp  = 4'(i % 7);
            t_rfc = 4'((i * 3) % 16);
            t_mrd = 4'(i % 5);
            w = {i[3:2], i[1:0], i[5:4], 16'((i * 1237) ^ 16'h05a5)};
            issue(w, ta);
            check_eq("R2 sweep pins", pins(), exp_pins(w));
            exp_gap = gap_of(w[19:18]);
            if (exp_gap > 1) check_eq("R4 ready low in gap", {31'b0, cmd_ready}, 32'h0);
            issue(22'h0c0000, tb);
            check_eq("R4 sweep gap", 32'(tb - ta), 32'(exp_gap));
        end

        // R5: write while busy is dropped
        t_rp = 4'd4;
        issue(22'h000000, ta);
        cmd_wr   = 1'b1;
        cmd_word = 22'h080032;
        @(negedge clk);
        cmd_wr = 1'b0;
        check_eq("R5 busy write no command", pins(), PINS_IDLE);
        issue(22'h1c0000, tb);
        check_eq("R5 gap unchanged", 32'(tb - ta), 32'd4);
        check_eq("R5 next pins", pins(), exp_pins(22'h1c0000));

        // R6: undefined state values ignored in configure
        for (int v = 1; v < 8; v++) begin
            if (v == 4) continue;
            write_cfg(3'(v));
            check_eq("R6 bad value in configure", {30'b0, cmd_ready, go_active}, 32'h2);
        end

        // R6 R7 R8 R9: periodic refresh over a sweep of intervals
        t_rfc = 4'd11;
        ivals[0] = 0; ivals[1] = 1; ivals[2] = 2; ivals[3] = 5;
        ivals[4] = 10; ivals[5] = 11; ivals[6] = 12; ivals[7] = 15;
        for (int j = 0; j < 9; j++) begin
            int iv, eff;
            iv  = (j == 8) ? 1037 : ivals[j];
            eff = (iv < 1) ? 1 : iv;
            while (!cmd_ready) @(negedge clk);
            ref_interval = 11'(iv);
            write_cfg(3'd0);
            c0 = cyc;
            check_eq("R6 go entered", {30'b0, cmd_ready, go_active}, 32'h1);
            cmd_wr   = 1'b1;
            cmd_word = 22'h0c0000;
            wait_refresh(t1);
            check_eq("R7 first refresh delay", 32'(t1 - c0), 32'(eff));
            check_eq("R8 refresh pins", pins(), PINS_REFRESH);
            wait_refresh(t2);
            check_eq("R7 refresh spacing", 32'(t2 - t1), 32'((eff > 11) ? eff : 11));
            if (j == 3) begin
                write_cfg(3'd6);
                check_eq("R6 bad value in go", {31'b0, go_active}, 32'h1);
            end
            write_cfg(3'd4);
            @(negedge clk);
            idle_bad = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (mem_cs_n != '1) idle_bad++;
            end
            check_eq("R9 no refresh after return", 32'(idle_bad), 32'd0);
            check_eq("R9 ready back", {30'b0, cmd_ready, go_active}, 32'h2);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule